// File: doc/BRIEF.md
# Envelope threshold flag generator

This block watches an unsigned 12-bit envelope magnitude, one value per clock, and raises two flag outputs that a gain-control loop or a host uses to react to signal level. Two upper limits yield peak indications that follow the envelope with no hold time. One lower limit yields a low-level indication. That indication appears only after the envelope has stayed under the limit for an unbroken dwell interval. Any excursion to or above the limit restarts the interval.

The dwell interval counts ticks of a divider that runs at the clock divided by 12 or by 16, chosen by a decimation select input. Its length is a mantissa shifted left by an exponent. Each flag output has its own source select and enable. Each output can also merge a fast converter-reset input into a peak source, which gives an overload indication that avoids the filter latency upstream. A threshold code follows code = 3584 + dBFS·256/3, so 0xE00 is full scale and 0xC00 is −6 dBFS. The comparators work on the codes directly.

Top module: `env_flag_gen`

## Requirements
- R1: Peak source 0 is high exactly when `envMag > peakThr0` (unsigned, strict). A selected and enabled output shows it one clock after the sample.
- R2: Peak source 1 is high exactly when `envMag > peakThr1` (unsigned, strict), with the same one-clock output latency.
- R3: Let T = `dwellMant` << `dwellExp`, held in 24 bits. Once `envMag < lowThr` (strict), the low source is set at the (T+1)-th divider tick. Every sample in between must also be below the limit. Equality with `lowThr` counts as not below.
- R4: Any sample with `envMag >= lowThr` clears the dwell count and the low source at once. A fresh full interval is then needed.
- R5: With `dwellMant` = 0, the low source sets at the first divider tick after the envelope drops, whatever the exponent.
- R6: The divider ticks once every 12 clocks when `decSel` = 0 and once every 16 clocks when `decSel` = 1.
- R7: Select code per output: 0 = peak 0, 1 = peak 1, 2 = low, 3 = converter reset. The converter-reset source shows `convReset` one clock later.
- R8: An output whose bit in `flagEn` is 0 is driven low one clock later, whatever its source.
- R9: When an output's bit in `orRstEn` is 1 and it selects peak 0 or peak 1, `convReset` is ORed into that source. The low source is not affected.
- R10: While `rstN` is low, both outputs are low and the dwell count and divider are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| envMag | input | 12 | Envelope magnitude code, one per clock |
| peakThr0 | input | 12 | Upper threshold 0 |
| peakThr1 | input | 12 | Upper threshold 1 |
| lowThr | input | 12 | Lower threshold |
| dwellMant | input | 8 | Dwell mantissa |
| dwellExp | input | 4 | Dwell exponent (left shift) |
| decSel | input | 1 | 0: tick every 12 clocks, 1: every 16 |
| convReset | input | 1 | Fast converter-reset event |
| flagSel0 | input | 2 | Source select for output 0 |
| flagSel1 | input | 2 | Source select for output 1 |
| flagEn | input | 2 | Per-output enable |
| orRstEn | input | 2 | Per-output reset-into-peak merge |
| flagOut | output | 2 | Registered flag outputs |

## Verification
The embedded properties assume that the select, enable and threshold inputs are held for at least two clocks around a sample of interest. This lets a value captured at one edge be compared with the output at the next. The dwell properties assume the limits and dwell settings do not change while a count is running. The stimulus changes configuration only on falling clock edges and only between dwell runs. Before each new dwell run it first drives the envelope above the lower limit, so that every run starts from a cleared count.

// File: rtl/envflag_pkg.sv
package envflag_pkg;

  typedef enum logic [1:0] {
    SRC_PEAK0 = 2'd0,
    SRC_PEAK1 = 2'd1,
    SRC_LOW   = 2'd2,
    SRC_CRST  = 2'd3
  } flagSrc_e;

  // strobes from control to datapath for the dwell counter and low flag
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic lowSet;
    logic lowClr;
  } dwellStrobe_t;

endpackage

// File: rtl/envflag_ctrl.sv
module envflag_ctrl
  import envflag_pkg::*;
#(
  parameter int DIV_A = 12,
  parameter int DIV_B = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         decSel,
  input  logic         below,
  input  logic         atTerm,
  output dwellStrobe_t strobe
);

  localparam int DIV_MAX = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int DIV_W   = $clog2(DIV_MAX);

  logic [DIV_W-1:0] tickCnt;
  logic [DIV_W-1:0] divLim;
  logic             tick;

  assign divLim = decSel ? DIV_W'(DIV_B - 1) : DIV_W'(DIV_A - 1);
  assign tick   = (tickCnt >= divLim);

  always_ff @(posedge clk) begin
    if (!rstN)     tickCnt <= '0;
    else if (tick) tickCnt <= '0;
    else           tickCnt <= tickCnt + 1'b1;
  end

  always_comb begin
    strobe.cntClr = !below;
    strobe.lowClr = !below;
    strobe.cntInc = below && tick && !atTerm;
    strobe.lowSet = below && tick && atTerm;
  end

  // ticks are isolated single-cycle pulses (R6)
  assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

  // a strobe never both clears and advances the dwell state (R4)
  assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.cntClr && (strobe.cntInc || strobe.lowSet)));

endmodule

// File: rtl/envflag_dp.sv
module envflag_dp
  import envflag_pkg::*;
#(
  parameter int THR_W  = 12,
  parameter int MANT_W = 8,
  parameter int EXP_W  = 4,
  parameter int CNT_W  = 24,
  parameter int NFLAG  = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [THR_W-1:0]      envMag,
  input  logic [THR_W-1:0]      peakThr0,
  input  logic [THR_W-1:0]      peakThr1,
  input  logic [THR_W-1:0]      lowThr,
  input  logic [MANT_W-1:0]     dwellMant,
  input  logic [EXP_W-1:0]      dwellExp,
  input  logic                  convReset,
  input  logic [NFLAG-1:0][1:0] flagSel,
  input  logic [NFLAG-1:0]      flagEn,
  input  logic [NFLAG-1:0]      orRstEn,
  input  dwellStrobe_t          strobe,
  output logic                  below,
  output logic                  atTerm,
  output logic [NFLAG-1:0]      flagOut
);

  logic             over0, over1;
  logic [CNT_W-1:0] terminal;
  logic [CNT_W-1:0] dwellCnt;
  logic             lowFlag;

  assign over0 = envMag > peakThr0;
  assign over1 = envMag > peakThr1;
  assign below = envMag < lowThr;

  assign terminal = {{(CNT_W-MANT_W){1'b0}}, dwellMant} << dwellExp;
  assign atTerm   = dwellCnt >= terminal;

  always_ff @(posedge clk) begin
    if (!rstN)               dwellCnt <= '0;
    else if (strobe.cntClr)  dwellCnt <= '0;
    else if (strobe.cntInc)  dwellCnt <= dwellCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               lowFlag <= 1'b0;
    else if (strobe.lowClr)  lowFlag <= 1'b0;
    else if (strobe.lowSet)  lowFlag <= 1'b1;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : gFlag
    logic srcVal;
    always_comb begin
      unique case (flagSrc_e'(flagSel[i]))
        SRC_PEAK0: srcVal = over0 || (orRstEn[i] && convReset);
        SRC_PEAK1: srcVal = over1 || (orRstEn[i] && convReset);
        SRC_LOW:   srcVal = lowFlag;
        default:   srcVal = convReset;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) flagOut[i] <= 1'b0;
      else       flagOut[i] <= flagEn[i] && srcVal;
    end

    assert_disabled_low_R8: assert property (@(posedge clk) disable iff (!rstN)
      !flagEn[i] |=> !flagOut[i]);

    assert_peak0_follow_R1: assert property (@(posedge clk) disable iff (!rstN)
      (flagEn[i] && flagSel[i] == 2'd0 && envMag > peakThr0) |=> flagOut[i]);

    assert_crst_follow_R7: assert property (@(posedge clk) disable iff (!rstN)
      (flagEn[i] && flagSel[i] == 2'd3 && convReset) |=> flagOut[i]);
  end

  assert_low_needs_below_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lowFlag) |-> $past(below));

  assert_excursion_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    !below |=> (!lowFlag && dwellCnt == '0));

endmodule

// File: rtl/env_flag_gen.sv
module env_flag_gen
  import envflag_pkg::*;
#(
  parameter int THR_W  = 12,
  parameter int MANT_W = 8,
  parameter int EXP_W  = 4,
  parameter int CNT_W  = 24,
  parameter int DIV_A  = 12,
  parameter int DIV_B  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [THR_W-1:0]  envMag,
  input  logic [THR_W-1:0]  peakThr0,
  input  logic [THR_W-1:0]  peakThr1,
  input  logic [THR_W-1:0]  lowThr,
  input  logic [MANT_W-1:0] dwellMant,
  input  logic [EXP_W-1:0]  dwellExp,
  input  logic              decSel,
  input  logic              convReset,
  input  logic [1:0]        flagSel0,
  input  logic [1:0]        flagSel1,
  input  logic [1:0]        flagEn,
  input  logic [1:0]        orRstEn,
  output logic [1:0]        flagOut
);

  dwellStrobe_t    strobe;
  logic            below, atTerm;
  logic [1:0][1:0] selVec;

  assign selVec = {flagSel1, flagSel0};

  envflag_ctrl #(.DIV_A(DIV_A), .DIV_B(DIV_B)) uCtrl (
    .clk(clk), .rstN(rstN), .decSel(decSel),
    .below(below), .atTerm(atTerm), .strobe(strobe)
  );

  envflag_dp #(
    .THR_W(THR_W), .MANT_W(MANT_W), .EXP_W(EXP_W), .CNT_W(CNT_W), .NFLAG(2)
  ) uDp (
    .clk(clk), .rstN(rstN), .envMag(envMag),
    .peakThr0(peakThr0), .peakThr1(peakThr1), .lowThr(lowThr),
    .dwellMant(dwellMant), .dwellExp(dwellExp), .convReset(convReset),
    .flagSel(selVec), .flagEn(flagEn), .orRstEn(orRstEn),
    .strobe(strobe), .below(below), .atTerm(atTerm), .flagOut(flagOut)
  );

endmodule

// File: tb/env_flag_gen_test.sv
module env_flag_gen_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic [11:0] envMag, peakThr0, peakThr1, lowThr;
  logic [7:0]  dwellMant;
  logic [3:0]  dwellExp;
  logic        decSel, convReset;
  logic [1:0]  flagSel0, flagSel1, flagEn, orRstEn;
  logic [1:0]  flagOut;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  env_flag_gen uut (
    .clk(clk), .rstN(rstN), .envMag(envMag), .peakThr0(peakThr0),
    .peakThr1(peakThr1), .lowThr(lowThr), .dwellMant(dwellMant),
    .dwellExp(dwellExp), .decSel(decSel), .convReset(convReset),
    .flagSel0(flagSel0), .flagSel1(flagSel1), .flagEn(flagEn),
    .orRstEn(orRstEn), .flagOut(flagOut)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [11:0] env;
    logic [11:0] thr0;
    logic [11:0] thr1;
    logic [1:0]  sel0;
    logic [1:0]  sel1;
    logic [1:0]  en;
    logic [1:0]  orEn;
    logic        crst;
    logic [1:0]  expOut;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{4'd1, 12'h801, 12'h800, 12'hE00, 2'd0, 2'd1, 2'b11, 2'b00, 1'b0, 2'b01}, // R1
    '{4'd2, 12'h800, 12'h800, 12'h7FF, 2'd0, 2'd1, 2'b11, 2'b00, 1'b0, 2'b10}, // R1 strict, R2
    '{4'd2, 12'hE01, 12'hF00, 12'hE00, 2'd0, 2'd1, 2'b11, 2'b00, 1'b0, 2'b10}, // R2
    '{4'd7, 12'h000, 12'hFFF, 12'hFFF, 2'd3, 2'd2, 2'b11, 2'b00, 1'b1, 2'b01}, // R7
    '{4'd7, 12'h000, 12'hFFF, 12'hFFF, 2'd3, 2'd2, 2'b11, 2'b00, 1'b0, 2'b00}, // R7
    '{4'd8, 12'hFFF, 12'h000, 12'h000, 2'd0, 2'd0, 2'b00, 2'b00, 1'b0, 2'b00}, // R8
    '{4'd8, 12'hFFF, 12'h000, 12'h000, 2'd0, 2'd0, 2'b01, 2'b00, 1'b0, 2'b01}, // R8
    '{4'd9, 12'h000, 12'hFFF, 12'hFFF, 2'd0, 2'd2, 2'b11, 2'b11, 1'b1, 2'b01}, // R9
    '{4'd9, 12'h000, 12'hFFF, 12'hFFF, 2'd0, 2'd2, 2'b11, 2'b00, 1'b1, 2'b00}, // R9
    '{4'd2, 12'hC01, 12'hFFF, 12'hC00, 2'd1, 2'd1, 2'b11, 2'b00, 1'b0, 2'b11}  // R2
  };

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: flagOut actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // dwell run: envelope above, drop, check low at loCyc and high at hiCyc after drop
  task automatic dwellRun(input string tag, input int loCyc, input int hiCyc);
    envMag = 12'h800;
    waitCyc(20);
    envMag = 12'h100;
    waitCyc(loCyc);
    chk(tag, flagOut, 2'b00);
    waitCyc(hiCyc - loCyc);
    chk(tag, flagOut, 2'b01);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; envMag = 12'hFFF; peakThr0 = 12'h000; peakThr1 = 12'h000;
    lowThr = 12'h000; dwellMant = 8'd0; dwellExp = 4'd0; decSel = 1'b0;
    convReset = 1'b1; flagSel0 = 2'd3; flagSel1 = 2'd0; flagEn = 2'b11; orRstEn = 2'b11;
    waitCyc(4);
    chk("R10 reset", flagOut, 2'b00);
    rstN = 1'b1; convReset = 1'b0; orRstEn = 2'b00;

    // table walk: drive at a falling edge, result registered at the next rising edge
    for (int i = 0; i < NVEC; i++) begin
      envMag = VECS[i].env; peakThr0 = VECS[i].thr0; peakThr1 = VECS[i].thr1;
      flagSel0 = VECS[i].sel0; flagSel1 = VECS[i].sel1; flagEn = VECS[i].en;
      orRstEn = VECS[i].orEn; convReset = VECS[i].crst;
      waitCyc(1);
      chk($sformatf("R%0d vec%0d", VECS[i].req, i), flagOut, VECS[i].expOut);
    end

    // dwell setup: output 0 on low source, output 1 disabled
    convReset = 1'b0; orRstEn = 2'b00; flagEn = 2'b01; flagSel0 = 2'd2; flagSel1 = 2'd0;
    peakThr0 = 12'hFFF; peakThr1 = 12'hFFF; lowThr = 12'h400;

    // R3: T = 3<<1 = 6, divide by 12 -> at most 6 ticks in 72 clocks
    dwellMant = 8'd3; dwellExp = 4'd1; decSel = 1'b0;
    dwellRun("R3 dwell 6 ticks", 72, 86);

    // R4: rise above clears promptly
    envMag = 12'h800;
    waitCyc(2);
    chk("R4 clear on rise", flagOut, 2'b00);

    // R4: excursion mid-interval restarts count
    envMag = 12'h100;
    waitCyc(50);
    envMag = 12'h400;  // equal: not below
    waitCyc(1);
    envMag = 12'h100;
    waitCyc(72);
    chk("R4 restart low", flagOut, 2'b00);
    waitCyc(14);
    chk("R4 restart high", flagOut, 2'b01);

    // R3: equality never counts as below
    envMag = 12'h400;
    waitCyc(200);
    chk("R3 equal stays low", flagOut, 2'b00);

    // R3: exponent shift, T = 1<<2 = 4
    dwellMant = 8'd1; dwellExp = 4'd2;
    dwellRun("R3 exponent", 48, 62);

    // R5: zero mantissa -> first tick
    dwellMant = 8'd0; dwellExp = 4'd5;
    dwellRun("R5 zero mantissa", 1, 14);

    // R6: divide by 16, T = 2
    decSel = 1'b1; dwellMant = 8'd2; dwellExp = 4'd0;
    dwellRun("R6 divide 16", 32, 50);

    // R9: low source unaffected by merge
    orRstEn = 2'b01; convReset = 1'b1; envMag = 12'h800;
    waitCyc(2);
    chk("R9 low unmerged", flagOut, 2'b00);

    // R10: mid-run reset clears output
    convReset = 1'b0; orRstEn = 2'b00;
    dwellRun("R10 pre-reset", 1, 60);
    rstN = 1'b0;
    waitCyc(1);
    chk("R10 reset clears", flagOut, 2'b00);
    rstN = 1'b1;

    done = 1'b1;
    summary();
    $finish;
  end

endmodule